// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block walks a list of register-write instructions held in memory and replays them as writes on a write-only register bus. Software places instructions in memory from a head byte address up to a tail byte address. It sets the enable bit and programs the head. Writing the tail then starts the run. The engine reads memory one 32-bit word at a time over a simple request/response port. It decodes each two-word instruction and issues the resulting writes with address, data and byte enables.

Two instruction forms produce writes. A direct write carries one value with its own byte enables. An indexed write carries a count N followed by N values, all sent to one register offset. When N is odd, one filler word restores 8-byte alignment. A pair whose opcode byte is zero does nothing, so the zero words that pad a buffer up to a 64-byte tail are consumed without effect. An unrecognised opcode halts the run and raises a sticky error flag. A normal end, when the fetch position meets the tail, gives a one-cycle done pulse.

Top module: `cmd_stream_exec`

## Requirements
- R1: After reset the control word (select 0) reads 0, and reg_we, mem_req and done are low.
- R2: A tail write while enable is 1 and the engine is idle starts fetching at the head. A tail write while enable is 0 issues no memory request and leaves busy at 0.
- R3: Busy (control bit 1) is high from the start until the run stops. On a normal stop, done is high for exactly one cycle, and that is the first cycle in which busy is low again.
- R4: When word1[31:24] = 0x01, the executor issues one write. The data is word0, the offset is word1[19:0] and the byte enables are word1[23:20].
- R5: When word1[31:24] = 0x09, word0 is a count N. The next N memory words are written in order to offset word1[19:0], all with byte enables 0xF.
- R6: After an indexed write with odd N, the one filler word is skipped and never read from memory. An indexed write with N = 0 issues no write.
- R7: When word1[31:24] = 0x00, the pair is a no-op. Runs of zero words produce no writes.
- R8: Any other opcode sets the sticky error bit (control bit 2) and clears busy, with no done pulse and no further writes. A control write with bit 2 set, made while idle, clears the error bit.
- R9: While busy, writes to the control, head and tail selects are ignored. In particular, enable keeps its value.
- R10: Each memory request lasts one cycle. Its byte address has its two low bits at zero. The executor waits for the response before it issues the next request.
- R11: Starting with head equal to tail gives a done pulse without any memory request.
- R12: Select 0 is control (bit 0 enable, bit 1 busy, bit 2 error), select 1 is the head and select 2 is the tail. The head and tail store their byte address with bits 2:0 forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_addr | input | 2 | Control register select (also used for reads) |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Read data of the selected control register |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response word |
| reg_we | output | 1 | Register bus write strobe |
| reg_addr | output | 20 | Register offset |
| reg_be | output | 4 | Byte enables |
| reg_wdata | output | 32 | Write data |
| done | output | 1 | One-cycle pulse at normal completion |

## Verification
The main buffer mixes a direct write with full byte enables and one with partial byte enables. It also holds an odd-count indexed write with its filler word, an even-count indexed write, a zero-count indexed write and a tail of zero pairs. Comparing the read count with the write list separates filler skipping from no-op decoding. A second buffer with a five-value burst checks that value order is kept and that odd-count filler is handled. Further runs cover a start while disabled, a start with head equal to tail, and a buffer with an unknown opcode in the middle; each of these is separated by its memory-read count, its done count and its control-word value. Memory latency rotates between one and three cycles, so any timing that assumes a fixed response delay shows up as a wrong write.

// File: rtl/cse_pkg.sv
package cse_pkg;

    localparam int DW        = 32;
    localparam int REG_OFF_W = 20;
    localparam int BE_W      = 4;

    localparam logic [7:0] OPC_NOP     = 8'h00;
    localparam logic [7:0] OPC_DIRECT  = 8'h01;
    localparam logic [7:0] OPC_INDEXED = 8'h09;

    localparam int CB_EN   = 0;
    localparam int CB_BUSY = 1;
    localparam int CB_ERR  = 2;

    typedef enum logic [1:0] {
        K_NOP, K_DIRECT, K_INDEXED, K_BAD
    } kind_e;

    typedef enum logic [1:0] {
        CSR_CTRL = 2'd0, CSR_HEAD = 2'd1, CSR_TAIL = 2'd2, CSR_NONE = 2'd3
    } csr_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_W0, S_W1, S_EXEC, S_DCHK, S_WD
    } seq_e;

    typedef struct packed {
        kind_e                 kind;
        logic [BE_W-1:0]       be;
        logic [REG_OFF_W-1:0]  off;
        logic [DW-1:0]         word0;
    } instr_t;

    typedef struct packed {
        logic [REG_OFF_W-1:0]  off;
        logic [BE_W-1:0]       be;
        logic [DW-1:0]         data;
    } wr_t;

    function automatic kind_e classify(input logic [7:0] opc);
        case (opc)
            OPC_NOP:     return K_NOP;
            OPC_DIRECT:  return K_DIRECT;
            OPC_INDEXED: return K_INDEXED;
            default:     return K_BAD;
        endcase
    endfunction

    function automatic logic [DW-1:0] ctrl_word(input logic en, input logic busy,
                                                input logic err);
        logic [DW-1:0] w;
        w = '0;
        w[CB_EN]   = en;
        w[CB_BUSY] = busy;
        w[CB_ERR]  = err;
        return w;
    endfunction

endpackage

// File: rtl/cse_csr.sv
module cse_csr
    import cse_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [DW-1:0]     wr_data,
    input  logic              busy,
    input  logic              err_set,
    output logic [DW-1:0]     rd_data,
    output logic              enable,
    output logic              err,
    output logic [ADDR_W-1:0] head,
    output logic [ADDR_W-1:0] tail,
    output logic              start
);
    logic accept;
    csr_e which;

    assign which  = csr_e'(sel);
    assign accept = wr_en && !busy;
    assign start  = accept && (which == CSR_TAIL) && enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            err    <= 1'b0;
            head   <= '0;
            tail   <= '0;
        end else begin
            if (err_set) begin
                err <= 1'b1;
            end
            if (accept) begin
                case (which)
                    CSR_CTRL: begin
                        enable <= wr_data[CB_EN];
                        if (wr_data[CB_ERR]) begin
                            err <= 1'b0;
                        end
                    end
                    CSR_HEAD: head <= {wr_data[ADDR_W-1:3], 3'b000};
                    CSR_TAIL: tail <= {wr_data[ADDR_W-1:3], 3'b000};
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (which)
            CSR_CTRL: rd_data = ctrl_word(enable, busy, err);
            CSR_HEAD: rd_data = DW'(head);
            CSR_TAIL: rd_data = DW'(tail);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cse_mem_rd.sv
module cse_mem_rd
    import cse_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     mem_rdata,
    output logic              got,
    output logic [DW-1:0]     got_data
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req  <= 1'b0;
            mem_addr <= '0;
            pend     <= 1'b0;
        end else begin
            mem_req <= go;
            if (go) begin
                mem_addr <= {go_addr[ADDR_W-1:2], 2'b00};
                pend     <= 1'b1;
            end else if (mem_rvalid) begin
                pend <= 1'b0;
            end
        end
    end

    assign got      = mem_rvalid && pend;
    assign got_data = mem_rdata;

endmodule

// File: rtl/cse_decode.sv
module cse_decode
    import cse_pkg::*;
(
    input  logic [DW-1:0] w0,
    input  logic [DW-1:0] w1,
    output instr_t        ins
);
    always_comb begin
        ins.kind  = classify(w1[31:24]);
        ins.be    = w1[23:20];
        ins.off   = w1[REG_OFF_W-1:0];
        ins.word0 = w0;
    end
endmodule

// File: rtl/cse_wr_out.sv
module cse_wr_out
    import cse_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  wr_t                  wr,
    output logic                 reg_we,
    output logic [REG_OFF_W-1:0] reg_addr,
    output logic [BE_W-1:0]      reg_be,
    output logic [DW-1:0]        reg_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_be    <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= go;
            if (go) begin
                reg_addr  <= wr.off;
                reg_be    <= wr.be;
                reg_wdata <= wr.data;
            end
        end
    end
endmodule

// File: rtl/cse_seq.sv
module cse_seq
    import cse_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] head,
    input  logic [ADDR_W-1:0] tail,
    input  logic              got,
    input  logic [DW-1:0]     got_data,
    input  instr_t            ins,
    output logic [DW-1:0]     w0,
    output logic [DW-1:0]     w1,
    output logic              rd_go,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_go,
    output wr_t               wr,
    output logic              err_set,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_PAIR = ADDR_W'(8);

    seq_e              st;
    logic [ADDR_W-1:0] pos;
    logic [DW-1:0]     remain;
    logic              finish;
    logic              done_q;

    assign busy = (st != S_IDLE);
    assign done = done_q;

    always_comb begin
        rd_go   = 1'b0;
        rd_addr = pos;
        wr_go   = 1'b0;
        wr.off  = ins.off;
        wr.be   = ins.be;
        wr.data = ins.word0;
        err_set = 1'b0;
        finish  = 1'b0;
        case (st)
            S_CHECK: begin
                if (pos == tail) finish = 1'b1;
                else             rd_go  = 1'b1;
            end
            S_W0: begin
                if (got) begin
                    rd_go   = 1'b1;
                    rd_addr = pos + STEP_WORD;
                end
            end
            S_EXEC: begin
                if (ins.kind == K_DIRECT) wr_go   = 1'b1;
                if (ins.kind == K_BAD)    err_set = 1'b1;
            end
            S_DCHK: begin
                if (remain != '0) begin
                    if (pos == tail) finish = 1'b1;
                    else             rd_go  = 1'b1;
                end
            end
            S_WD: begin
                if (got) begin
                    wr_go   = 1'b1;
                    wr.data = got_data;
                    wr.be   = '1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            pos    <= '0;
            w0     <= '0;
            w1     <= '0;
            remain <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        pos <= head;
                        st  <= S_CHECK;
                    end
                end
                S_CHECK: st <= finish ? S_IDLE : S_W0;
                S_W0: begin
                    if (got) begin
                        w0 <= got_data;
                        st <= S_W1;
                    end
                end
                S_W1: begin
                    if (got) begin
                        w1 <= got_data;
                        st <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    case (ins.kind)
                        K_INDEXED: begin
                            pos    <= pos + STEP_PAIR;
                            remain <= w0;
                            st     <= S_DCHK;
                        end
                        K_BAD:   st <= S_IDLE;
                        default: begin
                            pos <= pos + STEP_PAIR;
                            st  <= S_CHECK;
                        end
                    endcase
                end
                S_DCHK: begin
                    if (remain == '0) begin
                        if (w0[0]) pos <= pos + STEP_WORD;
                        st <= S_CHECK;
                    end else begin
                        st <= finish ? S_IDLE : S_WD;
                    end
                end
                S_WD: begin
                    if (got) begin
                        pos    <= pos + STEP_WORD;
                        remain <= remain - 1'b1;
                        st     <= S_DCHK;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmd_stream_exec.sv
module cmd_stream_exec
    import cse_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_we,
    input  logic [1:0]           ctl_addr,
    input  logic [DW-1:0]        ctl_wdata,
    output logic [DW-1:0]        ctl_rdata,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_rvalid,
    input  logic [DW-1:0]        mem_rdata,
    output logic                 reg_we,
    output logic [REG_OFF_W-1:0] reg_addr,
    output logic [BE_W-1:0]      reg_be,
    output logic [DW-1:0]        reg_wdata,
    output logic                 done
);
    logic              busy, enable, err, err_set, start;
    logic [ADDR_W-1:0] head, tail, rd_addr;
    logic              rd_go, got, wr_go;
    logic [DW-1:0]     got_data, w0, w1;
    instr_t            ins;
    wr_t               wr;

    cse_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk(clk), .rst(rst), .wr_en(ctl_we), .sel(ctl_addr), .wr_data(ctl_wdata),
        .busy(busy), .err_set(err_set), .rd_data(ctl_rdata), .enable(enable),
        .err(err), .head(head), .tail(tail), .start(start)
    );

    cse_mem_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst), .go(rd_go), .go_addr(rd_addr), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .got(got), .got_data(got_data)
    );

    cse_decode u_dec (.w0(w0), .w1(w1), .ins(ins));

    cse_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .head(head), .tail(tail), .got(got),
        .got_data(got_data), .ins(ins), .w0(w0), .w1(w1), .rd_go(rd_go),
        .rd_addr(rd_addr), .wr_go(wr_go), .wr(wr), .err_set(err_set),
        .busy(busy), .done(done)
    );

    cse_wr_out u_wr (
        .clk(clk), .rst(rst), .go(wr_go), .wr(wr), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata)
    );

endmodule

// File: rtl/cse_chk.sv
module cse_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              enable,
    input logic              err,
    input logic              done,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              reg_we
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R3
    AST_ENABLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> (enable == $past(enable))); // R9
    AST_ERR_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !busy); // R8
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R2
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R10
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R10
    AST_WRITE_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(busy)); // R4
endmodule

bind cmd_stream_exec cse_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .enable(enable), .err(err), .done(done),
    .mem_req(mem_req), .mem_addr(mem_addr), .reg_we(reg_we)
);

// File: tb/cmd_stream_exec_test.sv
module cmd_stream_exec_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we;
    logic [1:0]  ctl_addr;
    logic [31:0] ctl_wdata, ctl_rdata;
    logic        mem_req, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        reg_we;
    logic [19:0] reg_addr;
    logic [3:0]  reg_be;
    logic [31:0] reg_wdata;
    logic        done;

    cmd_stream_exec #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    int done_seen = 0, reads_seen = 0, req_total = 0;
    logic [31:0] mem [0:1023];
    logic [55:0] expq [$];
    bit exp_err;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // memory model with rotating latency 1..3
    logic [AW-1:0] pend_addr;
    int cd = 0;
    logic prev_req = 1'b0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst) begin
            cd <= 0;
            prev_req <= 1'b0;
        end else begin
            prev_req <= mem_req;
            if (mem_req) begin
                pend_addr <= mem_addr;
                cd <= 1 + (req_total % 3);
                req_total <= req_total + 1;
                reads_seen <= reads_seen + 1;
            end else if (cd != 0) begin
                cd <= cd - 1;
                if (cd == 1) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[pend_addr[11:2]];
                end
            end
        end
    end

    // reference comparison on every clock
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (mem_req) begin
                check(mem_addr[1:0] == 2'b00 && !prev_req, "R10 request shape",
                      {30'd0, mem_addr[1:0]}, 32'd0);
            end
            if (reg_we) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R4/R5 unexpected write", reg_wdata, 32'd0);
                end else begin
                    logic [55:0] e;
                    e = expq.pop_front();
                    check({reg_be, reg_addr, reg_wdata} == e, "R4/R5 write",
                          {reg_be, reg_addr[19:0], 8'h00} ^ reg_wdata, e[31:0]);
                end
            end
            if (done) done_seen++;
        end
    end

    task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        ctl_addr = a;
        #1 d = ctl_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin
            csr_rd(2'd0, v);
            n++;
        end while (v[1] && n < 5000);
        check(!v[1], "R3 busy falls", v, 32'd0);
    endtask

    // behavioural model of the instruction format
    task automatic model_run(input int head, input int tail);
        int pos = head;
        int guard = 0;
        exp_err = 0;
        while (pos != tail && guard < 2000) begin
            logic [31:0] a, b;
            guard++;
            a = mem[(pos >> 2) & 1023];
            b = mem[((pos >> 2) + 1) & 1023];
            case (b[31:24])
                8'h01: begin expq.push_back({b[23:20], b[19:0], a}); pos += 8; end
                8'h00: pos += 8;
                8'h09: begin
                    pos += 8;
                    for (int i = 0; i < a; i++) begin
                        if (pos == tail) break;
                        expq.push_back({4'hF, b[19:0], mem[(pos >> 2) & 1023]});
                        pos += 4;
                    end
                    if (a[0] && pos != tail) pos += 4;
                end
                default: begin exp_err = 1; break; end
            endcase
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        summary();
    end

    initial begin
        logic [31:0] v;
        int r0, d0;
        rst = 1'b1; ctl_we = 1'b0; ctl_addr = 2'd0; ctl_wdata = '0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
        // buffer A at 0x100..0x180
        mem[64] = 32'hA5A5_0001; mem[65] = 32'h01F0_1234;
        mem[66] = 32'd3;         mem[67] = 32'h0900_0040;
        mem[68] = 32'h11; mem[69] = 32'h22; mem[70] = 32'h33; mem[71] = 32'h0;
        mem[72] = 32'd2;         mem[73] = 32'h0900_0050;
        mem[74] = 32'h44; mem[75] = 32'h55;
        mem[76] = 32'hDEAD_BEEF; mem[77] = 32'h0130_0060;
        mem[78] = 32'd0;         mem[79] = 32'h0900_0070;
        // buffer D at 0x400..0x440 with a bad opcode
        mem[256] = 32'h77; mem[257] = 32'h01F0_0100;
        mem[258] = 32'h0;  mem[259] = 32'h0500_0000;
        mem[260] = 32'h99; mem[261] = 32'h01F0_0200;
        // buffer E at 0x600..0x640
        mem[384] = 32'd5; mem[385] = 32'h09F0_ABCD;
        for (int i = 0; i < 5; i++) mem[386 + i] = 32'h0101_0101 * (i + 1);
        mem[392] = 32'h1234_5678; mem[393] = 32'h01C0_0ABC;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        csr_rd(2'd0, v);
        check(v == 0, "R1 control after reset", v, 32'd0);
        check(!reg_we && !mem_req && !done, "R1 outputs idle",
              {29'd0, reg_we, mem_req, done}, 32'd0);

        // run A
        csr_wr(2'd0, 32'h1);
        csr_wr(2'd1, 32'h100);
        model_run(32'h100, 32'h180);
        r0 = reads_seen; d0 = done_seen;
        csr_wr(2'd2, 32'h180);
        csr_rd(2'd0, v);
        check(v[1] == 1'b1, "R3 busy during run", v, 32'h3);
        csr_wr(2'd0, 32'h0);
        csr_wr(2'd2, 32'h0);
        wait_idle();
        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R5 all writes seen", expq.size(), 32'd0);
        check(reads_seen - r0 == 31, "R6 filler skipped, R7 zero pairs read",
              reads_seen - r0, 32'd31);
        check(done_seen - d0 == 1, "R3 one done pulse", done_seen - d0, 32'd1);
        csr_rd(2'd0, v);
        check(v == 32'h1, "R9 enable kept", v, 32'h1);
        csr_rd(2'd2, v);
        check(v == 32'h180, "R9 tail kept", v, 32'h180);
        csr_rd(2'd1, v);
        check(v == 32'h100, "R12 head readback", v, 32'h100);

        // disabled start
        csr_wr(2'd0, 32'h0);
        r0 = reads_seen;
        csr_wr(2'd2, 32'h23F);
        repeat (10) @(negedge clk);
        check(reads_seen == r0, "R2 no fetch when disabled", reads_seen - r0, 32'd0);
        csr_rd(2'd0, v);
        check(v == 32'h0, "R2 busy stays low", v, 32'h0);
        csr_rd(2'd2, v);
        check(v == 32'h238, "R12 tail aligned", v, 32'h238);

        // head == tail
        csr_wr(2'd0, 32'h1);
        csr_wr(2'd1, 32'h207);
        csr_rd(2'd1, v);
        check(v == 32'h200, "R12 head aligned", v, 32'h200);
        r0 = reads_seen; d0 = done_seen;
        csr_wr(2'd2, 32'h200);
        wait_idle();
        repeat (2) @(negedge clk);
        check(done_seen - d0 == 1, "R11 done on empty", done_seen - d0, 32'd1);
        check(reads_seen == r0, "R11 no reads on empty", reads_seen - r0, 32'd0);

        // bad opcode
        csr_wr(2'd1, 32'h400);
        model_run(32'h400, 32'h440);
        check(exp_err == 1, "R8 model sees error", {31'd0, exp_err}, 32'd1);
        d0 = done_seen;
        csr_wr(2'd2, 32'h440);
        wait_idle();
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R8 writes before stop", expq.size(), 32'd0);
        check(done_seen == d0, "R8 no done", done_seen - d0, 32'd0);
        csr_rd(2'd0, v);
        check(v == 32'h5, "R8 error sticky", v, 32'h5);
        csr_wr(2'd0, 32'h5);
        csr_rd(2'd0, v);
        check(v == 32'h1, "R8 error cleared", v, 32'h1);

        // burst of five
        csr_wr(2'd1, 32'h600);
        model_run(32'h600, 32'h640);
        d0 = done_seen;
        csr_wr(2'd2, 32'h640);
        wait_idle();
        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R5 burst order", expq.size(), 32'd0);
        check(done_seen - d0 == 1, "R3 done after burst", done_seen - d0, 32'd1);

        // rerun A with shifted latency pattern
        csr_wr(2'd1, 32'h100);
        model_run(32'h100, 32'h180);
        csr_wr(2'd2, 32'h180);
        wait_idle();
        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R4 rerun writes", expq.size(), 32'd0);

        summary();
    end
endmodule